// File: doc/BRIEF.md
# UART Interrupt Priority Status Logic

This block gathers every interrupt condition of one serial channel and turns them into one status byte that the host can read. The byte shows only the highest-priority condition that is both pending and enabled. Five conditions are level-type: line error, receive data ready, receive timeout, transmit holding empty and modem status. They come from the rest of the channel and are reported for as long as they are held. Two conditions are enhanced and are latched inside this block: a flow-control or special-character match, and a rising edge on a flow-control pin. Each of these has its own clear rule.

The host issues a one-cycle read strobe when it reads the status byte. A read clears a latched enhanced condition only if that condition is the one the byte shows at the time. A special-character match also clears when the next character arrives. The two upper bits of the byte mirror the FIFO enable. A separate output tells whether the most recent flow-control match was Xoff or Xon.

Top module: `uart_irq_status`

## Requirements
- R1: During and after a synchronous reset, `status_o` is 8'h01 and `last_xoff_o` is 0.
- R2: `status_o[0]` is 0 whenever a source is reported. When nothing is pending, bits 5..0 read 000001.
- R3: Bits 5..0 report only the highest-priority pending source, one cycle after the inputs. The sources are listed from highest to lowest priority, with the enable bit index in brackets:
  - line error [0] = 000110
  - receive data ready [1] = 000100
  - receive timeout [2] = 001100
  - transmit holding empty [3] = 000010
  - modem status [4] = 000000
  - flow/special character [5] = 010000
  - flow pin rise [6] = 100000
- R4: A level source that has its bit of `src_en_i` at 0 has no effect on `status_o`. A level source stops being reported one cycle after its input drops, with no read needed.
- R5: The two enhanced sources are reported only while `ext_en_i` is 1 and their own enable bit is 1. A latched condition stays latched while it is hidden.
- R6: An Xon or Xoff match stays latched until a read strobe arrives while the status shows 010000. A read strobe that arrives while another code is shown leaves it latched.
- R7: A special-character match clears on a read strobe while 010000 is shown, or on `char_rx_i`, whichever comes first.
- R8: A low-to-high change on any bit of `flow_pin_i` latches the pin source. The change is seen after a two-flop synchroniser, and the synchroniser resets to 1. A high-to-low change latches nothing. A read strobe while 100000 is shown clears the pin source.
- R9: `status_o[7:6]` both equal `fifo_en_i`, registered one cycle.
- R10: `last_xoff_o` becomes 1 after an Xoff match and 0 after an Xon match. If both arrive in the same cycle, Xoff wins.
- R11: When a set and a clear of an enhanced source fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_err_i | input | 1 | Receive line status error (level) |
| rx_data_i | input | 1 | Receive data ready (level) |
| rx_tmo_i | input | 1 | Receive timeout (level) |
| tx_empty_i | input | 1 | Transmit holding empty (level) |
| modem_chg_i | input | 1 | Modem status change (level) |
| xon_hit_i | input | 1 | Xon character matched (pulse) |
| xoff_hit_i | input | 1 | Xoff character matched (pulse) |
| spec_hit_i | input | 1 | Special character matched (pulse) |
| flow_pin_i | input | NPINS | Asynchronous flow-control pins |
| src_en_i | input | 7 | Per-source enables, bit index as in R3 |
| ext_en_i | input | 1 | Enhanced features enable |
| fifo_en_i | input | 1 | FIFO enable flag |
| stat_rd_i | input | 1 | Host read of the status byte (pulse) |
| char_rx_i | input | 1 | Next character received (pulse) |
| status_o | output | 8 | Encoded interrupt status byte |
| last_xoff_o | output | 1 | 1: last flow match was Xoff; 0: Xon |

## Verification
Each source is first driven on its own, so that a wrong code for any single source shows up. Pairs and full sets of sources are then driven and withdrawn step by step from the top of the priority list, which separates a correct priority order from a swapped one. Read strobes are issued both while an enhanced code is shown and while it is hidden behind a higher source, which checks that a read clears only what the host actually saw. A strobe is also made to collide with a new match, which tells a set-wins flag from a clear-wins flag. The pin source is given both falling and rising edges, and the auto-clear of a special character is exercised by `char_rx_i`.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 7;
  localparam int IDX_LINE = 0;
  localparam int IDX_RXDATA = 1;
  localparam int IDX_RXTMO = 2;
  localparam int IDX_TXEMPTY = 3;
  localparam int IDX_MODEM = 4;
  localparam int IDX_FLOWCHR = 5;
  localparam int IDX_PINCHG = 6;

  localparam logic [5:0] CODE_NONE = 6'b000001;

  // Code reported for each source index; a lower index has higher priority
  function automatic logic [5:0] src_code(input int idx);
    logic [5:0] c;
    case (idx)
      IDX_LINE:    c = 6'b000110;
      IDX_RXDATA:  c = 6'b000100;
      IDX_RXTMO:   c = 6'b001100;
      IDX_TXEMPTY: c = 6'b000010;
      IDX_MODEM:   c = 6'b000000;
      IDX_FLOWCHR: c = 6'b010000;
      IDX_PINCHG:  c = 6'b100000;
      default:     c = CODE_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/uirq_pin_edge.sv
module uirq_pin_edge #(
  parameter int NPINS = 2,
  parameter int STAGES = 2,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  output logic             rise_o
);
  logic [NPINS-1:0] rise_vec;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= {STAGES{IDLE_LVL}};
        last_q <= IDLE_LVL;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_i[g]};
        last_q <= sync_q[STAGES-1];
      end
    end

    assign rise_vec[g] = sync_q[STAGES-1] & ~last_q;
  end

  assign rise_o = |rise_vec;
endmodule

// File: rtl/uirq_flags.sv
module uirq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;   // set has precedence over clear
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic [5:0]      code_o
);
  always_comb begin
    code_o = CODE_NONE;
    // walk from lowest priority up so the highest pending source is written last
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int NPINS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_err_i,
  input  logic             rx_data_i,
  input  logic             rx_tmo_i,
  input  logic             tx_empty_i,
  input  logic             modem_chg_i,
  input  logic             xon_hit_i,
  input  logic             xoff_hit_i,
  input  logic             spec_hit_i,
  input  logic [NPINS-1:0] flow_pin_i,
  input  logic [6:0]       src_en_i,
  input  logic             ext_en_i,
  input  logic             fifo_en_i,
  input  logic             stat_rd_i,
  input  logic             char_rx_i,
  output logic [7:0]       status_o,
  output logic             last_xoff_o
);
  localparam int NFLAG = 3;
  localparam int F_FLOW = 0;
  localparam int F_SPEC = 1;
  localparam int F_PIN  = 2;

  logic             pin_rise;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic [NSRC-1:0]  pend;
  logic [5:0]       code;
  logic             shows_chr, shows_pin;

  uirq_pin_edge #(.NPINS(NPINS), .STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_pin (
    .clk(clk), .rst(rst), .pin_i(flow_pin_i), .rise_o(pin_rise)
  );

  // a read only clears what the host saw in the byte it read
  assign shows_chr = (status_o[5:0] == src_code(IDX_FLOWCHR));
  assign shows_pin = (status_o[5:0] == src_code(IDX_PINCHG));

  assign flag_set[F_FLOW] = xon_hit_i | xoff_hit_i;
  assign flag_clr[F_FLOW] = stat_rd_i & shows_chr;
  assign flag_set[F_SPEC] = spec_hit_i;
  assign flag_clr[F_SPEC] = (stat_rd_i & shows_chr) | char_rx_i;
  assign flag_set[F_PIN]  = pin_rise;
  assign flag_clr[F_PIN]  = stat_rd_i & shows_pin;

  uirq_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag_q)
  );

  assign pend[IDX_LINE]    = line_err_i  & src_en_i[IDX_LINE];
  assign pend[IDX_RXDATA]  = rx_data_i   & src_en_i[IDX_RXDATA];
  assign pend[IDX_RXTMO]   = rx_tmo_i    & src_en_i[IDX_RXTMO];
  assign pend[IDX_TXEMPTY] = tx_empty_i  & src_en_i[IDX_TXEMPTY];
  assign pend[IDX_MODEM]   = modem_chg_i & src_en_i[IDX_MODEM];
  assign pend[IDX_FLOWCHR] = ext_en_i & src_en_i[IDX_FLOWCHR]
                             & (flag_q[F_FLOW] | flag_q[F_SPEC]);
  assign pend[IDX_PINCHG]  = ext_en_i & src_en_i[IDX_PINCHG] & flag_q[F_PIN];

  uirq_prio_enc u_enc (.pend_i(pend), .code_o(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= {2'b00, CODE_NONE};
      last_xoff_o <= 1'b0;
    end else begin
      status_o <= {fifo_en_i, fifo_en_i, code};
      if (xoff_hit_i)     last_xoff_o <= 1'b1;
      else if (xon_hit_i) last_xoff_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int NPINS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             line_err_i,
  input logic [NPINS-1:0] flow_pin_i,
  input logic [6:0]       src_en_i,
  input logic             ext_en_i,
  input logic             fifo_en_i,
  input logic             xon_hit_i,
  input logic             xoff_hit_i,
  input logic [7:0]       status_o,
  input logic             last_xoff_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_VAL: assert property (@(posedge clk) rst |=> (status_o == 8'h01 && !last_xoff_o)); // R1
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    status_o[0] |-> (status_o[5:1] == 5'b0)); // R2
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(line_err_i && src_en_i[0])) |-> (status_o[5:0] == 6'b000110)); // R3
  AST_ENH_GATE: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(ext_en_i)) |-> (status_o[5:4] == 2'b00)); // R5
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
    armed |-> (status_o[7:6] == {2{$past(fifo_en_i)}})); // R9
  AST_XOFF_LAST: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(xoff_hit_i)) |-> last_xoff_o); // R10
  AST_XON_LAST: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(xon_hit_i && !xoff_hit_i)) |-> !last_xoff_o); // R10
endmodule

bind uart_irq_status uart_irq_status_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .line_err_i(line_err_i), .flow_pin_i(flow_pin_i),
  .src_en_i(src_en_i), .ext_en_i(ext_en_i), .fifo_en_i(fifo_en_i),
  .xon_hit_i(xon_hit_i), .xoff_hit_i(xoff_hit_i),
  .status_o(status_o), .last_xoff_o(last_xoff_o)
);

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
  localparam int NPINS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_err = 0, rx_data = 0, rx_tmo = 0, tx_empty = 0, modem_chg = 0;
  logic xon_hit = 0, xoff_hit = 0, spec_hit = 0;
  logic [NPINS-1:0] flow_pin = '1;
  logic [6:0] src_en = 7'h7f;
  logic ext_en = 1, fifo_en = 0, stat_rd = 0, char_rx = 0;
  logic [7:0] status;
  logic last_xoff;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_irq_status #(.NPINS(NPINS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .line_err_i(line_err), .rx_data_i(rx_data),
    .rx_tmo_i(rx_tmo), .tx_empty_i(tx_empty), .modem_chg_i(modem_chg),
    .xon_hit_i(xon_hit), .xoff_hit_i(xoff_hit), .spec_hit_i(spec_hit),
    .flow_pin_i(flow_pin), .src_en_i(src_en), .ext_en_i(ext_en),
    .fifo_en_i(fifo_en), .stat_rd_i(stat_rd), .char_rx_i(char_rx),
    .status_o(status), .last_xoff_o(last_xoff)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clr_levels();
    line_err = 0; rx_data = 0; rx_tmo = 0; tx_empty = 0; modem_chg = 0;
  endtask

  task automatic read_pulse();
    stat_rd = 1; step(1); stat_rd = 0; step(1);
  endtask

  task automatic t_reset();
    step(1);
    chk("R1 status in reset", status, 8'h01);
    rst = 0; step(1);
    chk("R1 status after reset", status, 8'h01);
    chk("R1 last_xoff after reset", {7'b0, last_xoff}, 8'h00);
  endtask

  task automatic t_singles();
    line_err = 1; step(1); chk("R3 line alone", status, 8'h06); clr_levels();
    rx_data = 1;  step(1); chk("R3 rxdata alone", status, 8'h04); clr_levels();
    rx_tmo = 1;   step(1); chk("R3 timeout alone", status, 8'h0C); clr_levels();
    tx_empty = 1; step(1); chk("R3 txempty alone", status, 8'h02); clr_levels();
    modem_chg = 1; step(1); chk("R2 modem alone bit0=0", status, 8'h00); clr_levels();
    step(1); chk("R4 level drop no read", status, 8'h01);
  endtask

  task automatic t_priority();
    line_err = 1; rx_data = 1; rx_tmo = 1; tx_empty = 1; modem_chg = 1;
    step(1); chk("R3 all -> line", status, 8'h06);
    line_err = 0; step(1); chk("R3 rxdata over timeout", status, 8'h04);
    rx_data = 0;  step(1); chk("R3 timeout over txempty", status, 8'h0C);
    rx_tmo = 0;   step(1); chk("R3 txempty over modem", status, 8'h02);
    tx_empty = 0; step(1); chk("R3 modem last level", status, 8'h00);
    clr_levels(); step(1);
  endtask

  task automatic t_enables();
    src_en = 7'h7e; line_err = 1; rx_tmo = 1;
    step(1); chk("R4 disabled line ignored", status, 8'h0C);
    src_en = 7'h7a; step(1); chk("R4 all enabled off -> none", status, 8'h01);
    src_en = 7'h7f; clr_levels(); step(1);
  endtask

  task automatic t_xonxoff();
    xoff_hit = 1; step(1); xoff_hit = 0; step(1);
    chk("R6 xoff reported", status, 8'h10);
    chk("R10 last is xoff", {7'b0, last_xoff}, 8'h01);
    line_err = 1; step(1); chk("R3 line over flowchr", status, 8'h06);
    read_pulse();
    line_err = 0; step(1); chk("R6 hidden read keeps flag", status, 8'h10);
    read_pulse(); chk("R6 shown read clears", status, 8'h01);
    xon_hit = 1; step(1); xon_hit = 0; step(1);
    chk("R10 last is xon", {7'b0, last_xoff}, 8'h00);
    // collision: read while shown and a new match in the same cycle
    stat_rd = 1; xon_hit = 1; step(1); stat_rd = 0; xon_hit = 0; step(1);
    chk("R11 set wins over read", status, 8'h10);
    read_pulse(); chk("R11 later read clears", status, 8'h01);
    xon_hit = 1; xoff_hit = 1; step(1); xon_hit = 0; xoff_hit = 0; step(1);
    chk("R10 both -> xoff", {7'b0, last_xoff}, 8'h01);
    read_pulse();
  endtask

  task automatic t_special();
    spec_hit = 1; step(1); spec_hit = 0; step(1);
    chk("R7 special reported", status, 8'h10);
    char_rx = 1; step(1); char_rx = 0; step(1);
    chk("R7 auto clear on next char", status, 8'h01);
    spec_hit = 1; step(1); spec_hit = 0; step(1);
    read_pulse(); chk("R7 read clears special", status, 8'h01);
    spec_hit = 1; char_rx = 1; step(1); spec_hit = 0; char_rx = 0; step(1);
    chk("R11 special set wins over char", status, 8'h10);
    char_rx = 1; step(1); char_rx = 0; step(1);
  endtask

  task automatic t_enh_gate();
    ext_en = 0; spec_hit = 1; step(1); spec_hit = 0; step(1);
    chk("R5 hidden when ext off", status, 8'h01);
    ext_en = 1; step(1); chk("R5 shown when ext on", status, 8'h10);
    src_en = 7'h5f; step(1); chk("R5 own enable off", status, 8'h01);
    src_en = 7'h7f; read_pulse(); read_pulse();
    chk("R5 cleared", status, 8'h01);
  endtask

  task automatic t_pin();
    flow_pin = 2'b10; step(5);
    chk("R8 falling edge ignored", status, 8'h01);
    flow_pin = 2'b11; step(4);
    chk("R8 rising edge latched", status, 8'h20);
    tx_empty = 1; step(1); chk("R3 txempty over pin", status, 8'h02);
    read_pulse(); tx_empty = 0; step(1);
    chk("R8 hidden read keeps pin", status, 8'h20);
    read_pulse(); chk("R8 shown read clears pin", status, 8'h01);
  endtask

  task automatic t_fifo();
    fifo_en = 1; step(1); chk("R9 fifo on", status, 8'hC1);
    rx_data = 1; step(1); chk("R9 fifo on with rxdata", status, 8'hC4);
    fifo_en = 0; clr_levels(); step(1); chk("R9 fifo off", status, 8'h01);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    step(3);
    t_reset();
    t_singles();
    t_priority();
    t_enables();
    t_xonxoff();
    t_special();
    t_enh_gate();
    t_pin();
    t_fifo();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule